// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter

This block connects a processor whose bus carries the low address byte and the data byte on the same eight lines to a small memory device. The processor drives a dedicated high address byte on separate output-only lines. The shared lines carry the low address byte at the start of a bus cycle and data later in that cycle. A strobe marks when the lines hold address. The block captures the low byte while that strobe is high and keeps it once the strobe drops. This leaves a stable full address in place after the lines have turned around to carry data.

From the six uppermost address bits and the memory/IO select, the block decodes a chip select for a 1 KB memory window, and it passes the ten low address bits on to the device. The active-low read and write strobes become active-high memory read and write enables. The block owns the direction of the shared lines. It asks to drive them toward the processor only during a selected read, and at all other times it leaves them released. A parameter chooses a read-only target, which has no write enable, or a read/write target. Every output is registered one clock after the inputs are sampled.

Top module: `ad_bus_splitter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output goes to 0 after that edge, and the held low address byte is cleared to 0.
- R2: When `ale_i` is 1 at a rising edge, `addr_o[7:0]` after that edge equals `ad_in_i` as sampled at that edge, and this value becomes the held low byte.
- R3: When `ale_i` is 0 at a rising edge, the held low byte keeps its value, so `addr_o[7:0]` does not change whatever `ad_in_i` carries.
- R4: After each rising edge, `addr_o[15:8]` equals `hi_addr_i` as sampled at that edge, and `mem_addr_o` equals `addr_o[9:0]`.
- R5: `mem_cs_o` is 1 after an edge exactly when, at that edge, `mio_i` was 1 (1 means a memory access) and `hi_addr_i[7:2]` equalled the parameter `WIN_BASE` (default 5, which gives addresses 0x1400 to 0x17FF).
- R6: `mem_rd_o` is 1 after an edge exactly when chip select was decoded at that edge, `rd_n_i` was 0 and `wr_n_i` was 1.
- R7: With `IS_RAM`=1, `mem_wr_o` is 1 after an edge exactly when chip select was decoded, `wr_n_i` was 0 and `rd_n_i` was 1. With `IS_RAM`=0, `mem_wr_o` is always 0.
- R8: `ad_oe_o` is 1 only after an edge where a selected read was decoded, as in R6. `ad_out_o` is `mem_rdata_i` as sampled at the previous edge.
- R9: If `rd_n_i` and `wr_n_i` are both 0 at an edge, then `mem_rd_o`, `mem_wr_o` and `ad_oe_o` are all 0 after that edge.
- R10: `mem_wdata_o` equals `ad_in_i` as sampled at the previous edge.
- R11: When `mio_i` is 0 at an edge, then `mem_cs_o`, `mem_rd_o`, `mem_wr_o` and `ad_oe_o` are all 0 after that edge, for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hi_addr_i | input | 8 | Dedicated high address byte from the processor |
| ad_in_i | input | 8 | Value present on the shared address/data lines |
| ad_out_o | output | 8 | Read data to place on the shared lines |
| ad_oe_o | output | 1 | Drive enable for the shared lines toward the processor |
| ale_i | input | 1 | Address-latch strobe, active high |
| mio_i | input | 1 | 1 = memory access, 0 = I/O access |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_o | output | 16 | Full demultiplexed address |
| mem_addr_o | output | 10 | Address inside the 1 KB window |
| mem_cs_o | output | 1 | Chip select for the memory device |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Write data taken from the shared lines |
| mem_rdata_i | input | 8 | Read data from the memory device |

## Verification
A corrupted held low byte shows on `addr_o[7:0]` and `mem_addr_o` in the first cycle after the fault, and it stays wrong until the next strobe recaptures the byte. The bench therefore holds the strobe low for long random stretches while the shared lines keep changing. A wrong window compare or a wrong memory/IO qualification shows on `mem_cs_o` one cycle after the address reaches the inputs. Because the enables and the drive enable follow that same chip select, a decode fault also shows on them in the same cycle. An error in the strobe decode reaches `mem_rd_o`, `mem_wr_o` or `ad_oe_o` within one cycle, and the directed case with both strobes low catches a design that lets one strobe win over the other.

// File: rtl/ad_split_pkg.sv
package ad_split_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic oe;
  } mem_ctl_t;

  // Turn the qualified select and the active-low strobes into memory controls.
  // When both strobes are low, the access is ambiguous and no control is raised.
  function automatic mem_ctl_t decode_ctl(input logic sel, input logic rd_n,
                                          input logic wr_n, input logic ram);
    mem_ctl_t c;
    c.rd = sel & ~rd_n & wr_n;
    c.wr = sel & ~wr_n & rd_n & ram;
    c.oe = sel & ~rd_n & wr_n;
    return c;
  endfunction

endpackage

// File: rtl/lo_addr_hold.sv
module lo_addr_hold #(
  parameter int unsigned HI_W = 8,
  parameter int unsigned LO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic [LO_W-1:0]      ad_i,
  output logic [HI_W+LO_W-1:0] addr_o
);
  localparam int unsigned AW = HI_W + LO_W;

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_next;
  logic [AW-1:0]   addr_q;

  // Transparent while the strobe is high; frozen once it falls.
  assign lo_next = ale_i ? ad_i : lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      addr_q <= '0;
    end else begin
      lo_q   <= lo_next;
      addr_q <= {hi_i, lo_next};
    end
  end

  assign addr_o = addr_q;

  a_r2_capture_on_strobe: assert property (@(posedge clk) disable iff (rst)
    ale_i |=> (addr_q[LO_W-1:0] == $past(ad_i)));

  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !ale_i |=> $stable(lo_q));

  a_r4_high_byte_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_q[AW-1:LO_W] == $past(hi_i)));

endmodule

// File: rtl/win_select.sv
module win_select #(
  parameter int unsigned HI_W     = 8,
  parameter int unsigned LO_W     = 8,
  parameter int unsigned WIN_BITS = 10,
  parameter int unsigned WIN_BASE = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mio_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            sel_next_o,
  output logic            cs_o
);
  localparam int unsigned AW    = HI_W + LO_W;
  localparam int unsigned TAG_W = AW - WIN_BITS;

  logic [TAG_W-1:0] tag;
  logic             cs_q;

  assign tag        = hi_i[HI_W-1:HI_W-TAG_W];
  assign sel_next_o = mio_i && (tag == TAG_W'(WIN_BASE));

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b0;
    else     cs_q <= sel_next_o;
  end

  assign cs_o = cs_q;

  a_r11_io_never_selects: assert property (@(posedge clk) disable iff (rst)
    !mio_i |=> !cs_q);

  a_r5_window_hit_selects: assert property (@(posedge clk) disable iff (rst)
    (mio_i && (hi_i[HI_W-1:HI_W-TAG_W] == TAG_W'(WIN_BASE))) |=> cs_q);

  a_r5_window_miss_deselects: assert property (@(posedge clk) disable iff (rst)
    (hi_i[HI_W-1:HI_W-TAG_W] != TAG_W'(WIN_BASE)) |=> !cs_q);

endmodule

// File: rtl/strobe_ctl.sv
module strobe_ctl
  import ad_split_pkg::*;
#(
  parameter int unsigned LO_W   = 8,
  parameter bit          IS_RAM = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  input  logic [LO_W-1:0] ad_i,
  input  logic [LO_W-1:0] rdata_i,
  output logic            rd_o,
  output logic            wr_o,
  output logic            oe_o,
  output logic [LO_W-1:0] wdata_o,
  output logic [LO_W-1:0] rdata_o
);
  mem_ctl_t        ctl;
  mem_ctl_t        ctl_q;
  logic [LO_W-1:0] wdata_q;
  logic [LO_W-1:0] rdata_q;

  assign ctl = decode_ctl(sel_i, rd_n_i, wr_n_i, IS_RAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ctl_q   <= ctl;
      wdata_q <= ad_i;
      rdata_q <= rdata_i;
    end
  end

  assign rd_o    = ctl_q.rd;
  assign oe_o    = ctl_q.oe;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  generate
    if (IS_RAM) begin : g_ram
      assign wr_o = ctl_q.wr;
      a_r7_write_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !wr_n_i && rd_n_i) |=> wr_o);
    end else begin : g_rom
      assign wr_o = 1'b0;
    end
  endgenerate

  a_r9_conflict_blocks_all: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_i && !wr_n_i) |=> (!rd_o && !wr_o && !oe_o));

  a_r6_read_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !rd_n_i && wr_n_i) |=> rd_o);

  a_r10_wdata_follows_lines: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wdata_q == $past(ad_i)));

endmodule

// File: rtl/ad_bus_splitter.sv
module ad_bus_splitter #(
  parameter int unsigned HI_W     = 8,
  parameter int unsigned LO_W     = 8,
  parameter int unsigned WIN_BITS = 10,
  parameter int unsigned WIN_BASE = 5,
  parameter bit          IS_RAM   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HI_W-1:0]      hi_addr_i,
  input  logic [LO_W-1:0]      ad_in_i,
  output logic [LO_W-1:0]      ad_out_o,
  output logic                 ad_oe_o,
  input  logic                 ale_i,
  input  logic                 mio_i,
  input  logic                 rd_n_i,
  input  logic                 wr_n_i,
  output logic [HI_W+LO_W-1:0] addr_o,
  output logic [WIN_BITS-1:0]  mem_addr_o,
  output logic                 mem_cs_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic [LO_W-1:0]      mem_wdata_o,
  input  logic [LO_W-1:0]      mem_rdata_i
);
  logic sel_next;

  lo_addr_hold #(.HI_W(HI_W), .LO_W(LO_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .ale_i  (ale_i),
    .hi_i   (hi_addr_i),
    .ad_i   (ad_in_i),
    .addr_o (addr_o)
  );

  win_select #(
    .HI_W(HI_W), .LO_W(LO_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .mio_i      (mio_i),
    .hi_i       (hi_addr_i),
    .sel_next_o (sel_next),
    .cs_o       (mem_cs_o)
  );

  strobe_ctl #(.LO_W(LO_W), .IS_RAM(IS_RAM)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_next),
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .ad_i    (ad_in_i),
    .rdata_i (mem_rdata_i),
    .rd_o    (mem_rd_o),
    .wr_o    (mem_wr_o),
    .oe_o    (ad_oe_o),
    .wdata_o (mem_wdata_o),
    .rdata_o (ad_out_o)
  );

  assign mem_addr_o = addr_o[WIN_BITS-1:0];

  a_r8_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
    ad_oe_o |-> (mem_cs_o && mem_rd_o));

  a_r11_enables_need_select: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o || mem_wr_o) |-> mem_cs_o);

endmodule

// File: tb/ad_bus_splitter_bench.sv
`timescale 1ns/1ps
module ad_bus_splitter_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  hi, ad, rdata;
  logic        ale, mio, rd_n, wr_n;
  logic [7:0]  ad_out, wdata, r_ad_out, r_wdata;
  logic        oe, cs, rd, wr, r_oe, r_cs, r_rd, r_wr;
  logic [15:0] addr, r_addr;
  logic [9:0]  maddr, r_maddr;

  int tests = 0;
  int fails = 0;

  // expected values for the outputs after the coming edge
  logic [7:0]  lo_m;
  logic [15:0] e_addr;
  logic        e_cs, e_rd, e_wr, e_oe;
  logic [7:0]  e_out, e_wd;

  always #2 clk = ~clk;

  ad_bus_splitter u_ad_bus_splitter (
    .clk(clk), .rst(rst), .hi_addr_i(hi), .ad_in_i(ad), .ad_out_o(ad_out),
    .ad_oe_o(oe), .ale_i(ale), .mio_i(mio), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .addr_o(addr), .mem_addr_o(maddr), .mem_cs_o(cs), .mem_rd_o(rd),
    .mem_wr_o(wr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  ad_bus_splitter #(.IS_RAM(1'b0)) u_rom (
    .clk(clk), .rst(rst), .hi_addr_i(hi), .ad_in_i(ad), .ad_out_o(r_ad_out),
    .ad_oe_o(r_oe), .ale_i(ale), .mio_i(mio), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .addr_o(r_addr), .mem_addr_o(r_maddr), .mem_cs_o(r_cs), .mem_rd_o(r_rd),
    .mem_wr_o(r_wr), .mem_wdata_o(r_wdata), .mem_rdata_i(rdata)
  );

  function automatic logic in_win(input logic m, input logic [7:0] h);
    return m && (h[7:2] == 6'd5);
  endfunction

  function automatic logic exp_rd(input logic s, input logic r_n, input logic w_n);
    return s && !r_n && w_n;
  endfunction

  function automatic logic exp_wr(input logic s, input logic r_n, input logic w_n);
    return s && !w_n && r_n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2/R3/R4 addr", addr, e_addr);
    chk("R4 mem_addr", maddr, e_addr[9:0]);
    chk("R5/R11 cs", cs, e_cs);
    chk("R6/R9 rd", rd, e_rd);
    chk("R7/R9 wr", wr, e_wr);
    chk("R8 oe", oe, e_oe);
    chk("R8 ad_out", ad_out, e_out);
    chk("R10 wdata", wdata, e_wd);
    chk("R7 rom wr", r_wr, 1'b0);
    chk("R8 rom oe", r_oe, e_oe);
  endtask

  // check outputs from the previous edge, then drive the next inputs
  task automatic step(input logic r, input logic [7:0] h, input logic [7:0] a,
                      input logic l, input logic m, input logic rn, input logic wn,
                      input logic [7:0] d);
    logic s;
    @(negedge clk);
    check_all();
    rst = r; hi = h; ad = a; ale = l; mio = m; rd_n = rn; wr_n = wn; rdata = d;
    if (r) begin
      lo_m = 8'h00; e_addr = 16'h0; e_cs = 0; e_rd = 0; e_wr = 0; e_oe = 0;
      e_out = 8'h00; e_wd = 8'h00;
    end else begin
      if (l) lo_m = a;
      s      = in_win(m, h);
      e_addr = {h, lo_m};
      e_cs   = s;
      e_rd   = exp_rd(s, rn, wn);
      e_wr   = exp_wr(s, rn, wn);
      e_oe   = e_rd;
      e_out  = d;
      e_wd   = a;
    end
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; hi = 8'hff; ad = 8'hff; ale = 1; mio = 1; rd_n = 0; wr_n = 1; rdata = 8'hff;
    lo_m = 0; e_addr = 0; e_cs = 0; e_rd = 0; e_wr = 0; e_oe = 0; e_out = 0; e_wd = 0;
    @(negedge clk);
    // R1: reset with active-looking inputs still yields all-zero outputs
    step(1, 8'h14, 8'hA5, 1, 1, 0, 1, 8'h3C);
    step(1, 8'h14, 8'hA5, 1, 1, 0, 1, 8'h3C);
    // R2: capture, then R3: hold while the lines carry data
    step(0, 8'h15, 8'h5A, 1, 1, 1, 1, 8'h00);
    step(0, 8'h15, 8'hC3, 0, 1, 0, 1, 8'h77);
    step(0, 8'h15, 8'h0F, 0, 1, 1, 0, 8'h11);
    // R9: both strobes low inside the window
    step(0, 8'h16, 8'h22, 0, 1, 0, 0, 8'h99);
    // R11: I/O access at a window address
    step(0, 8'h17, 8'h33, 1, 0, 0, 1, 8'h44);
    step(0, 8'h17, 8'h34, 0, 0, 1, 0, 8'h45);
    // R5: window edges
    step(0, 8'h13, 8'hFF, 1, 1, 0, 1, 8'h01);
    step(0, 8'h18, 8'h00, 1, 1, 0, 1, 8'h02);
    step(0, 8'h14, 8'h00, 1, 1, 1, 0, 8'h03);
    step(0, 8'h17, 8'hFF, 1, 1, 0, 1, 8'h04);
    // random traffic with long strobe-low stretches
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] h;
      logic [1:0] st;
      h = 8'($urandom);
      if ($urandom % 2 == 0) h[7:2] = 6'd5;
      st = 2'($urandom);
      step(($urandom % 97) == 0, h, 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) != 0, st[0], st[1], 8'($urandom));
    end
    step(0, 8'h00, 8'h00, 0, 0, 1, 1, 8'h00);
    @(negedge clk);
    check_all();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule